// File: doc/BRIEF.md
# Fine Delay Tracking Controller

This block steers the fine half of a two-stage delay-locked frequency discriminator. The coarse stage sets a wide-range delay first. After that, this controller owns a small digital code that a resistor DAC turns into a varactor tuning voltage. The code therefore sets a small added delay. The controller holds the code at zero until the coarse stage reports that it has finished.

Once the coarse stage has finished, the controller moves the code by one step at each decision. A decision is taken on each pulse of an update strobe. The strobe is spaced externally, so that the DAC filter can settle between decisions. The direction of each step follows the phase detector. A lagging line, flagged by UP, calls for more delay; the DN output calls for less. When the sensor frequency falls, the divided period grows and the code climbs until the line matches again. The controller never stops tracking, so later frequency shifts are followed in the same way. One code step corresponds to a few picoseconds of divided-clock period.

The outputs are the code itself and three flags: a lock flag, a one-cycle pulse that marks each code change for readout, and a flag that shows the code is pinned against one of its limits.

Top module: `fine_track_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the code to 0 and clears the lock, change and saturation flags.
- R2: While `coarse_done` is low, the code is 0 from the next clock edge on, all three flags are 0, and `up`, `dn` and `upd_stb` have no effect.
- R3: A decision is taken only on a clock edge at which both `upd_stb` and `coarse_done` are high. On any other edge the code holds its value.
- R4: At a decision, `up`=1 with `dn`=0 raises the code by exactly one, and `dn`=1 with `up`=0 lowers it by exactly one. The new code is visible after that edge.
- R5: At a decision, `up` and `dn` both high or both low leave the code unchanged.
- R6: The code stops at 0 and at 31 and does not wrap. `fine_sat` is 1 after a decision whose requested step was blocked by a limit. It stays 1 until the next decision that is not blocked.
- R7: `code_chg` is high for exactly the one cycle after a decision that moved the code, and is low at all other times.
- R8: `fine_lock` rises once LOCK_K consecutive decisions have each either held the code or stepped opposite to the most recent step.
- R9: A step in the same direction as the most recent step clears `fine_lock` and restarts the count. Holding decisions in between do not separate the two steps.
- R10: Under a phase detector driven by the code's delay, the code rises after a drop in the sensor frequency, settles to within one step of the new match, and locks again. A later drop is followed in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coarse_done | input | 1 | Coarse loop has fixed its code; enables tracking |
| up | input | 1 | Phase detector: more delay needed |
| dn | input | 1 | Phase detector: less delay needed |
| upd_stb | input | 1 | One-cycle decision strobe |
| fine_code | output | CODE_W | Fine delay code for the DAC |
| fine_lock | output | 1 | Fine loop locked |
| code_chg | output | 1 | One-cycle pulse after a code change |
| fine_sat | output | 1 | Last decision was blocked at a code limit |

## Verification
The bench keeps the default 5-bit code, so it must climb through all 32 code values to reach the ceiling. It builds the lock detector with LOCK_K=3. With that setting, entering lock, holding lock through reversals and losing it on a repeated step all happen within a few decisions of a short vector table. A closed-loop model turns the code into delay, in picoseconds, against a required period. It issues decisions every fourth cycle and lowers the sensor frequency twice, which exercises re-locking at two separate code values.

// File: rtl/ftc_pkg.sv
// Shared types for the fine delay tracking controller.
package ftc_pkg;
    // Direction of one code step, as requested or as actually applied.
    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_INC  = 2'd1,
        MV_DEC  = 2'd2
    } move_t;
endpackage

// File: rtl/ftc_decide.sv
// Turns the phase detector outputs into one step request per decision.
// Assumes upd_stb is a single-cycle pulse spaced for the DAC to settle.
// A request for both directions, or for none, yields no step.
module ftc_decide
    import ftc_pkg::*;
(
    input  logic  enable,
    input  logic  upd_stb,
    input  logic  up,
    input  logic  dn,
    output logic  decide,
    output move_t req
);
    // Gate the strobe with enable and resolve the direction.
    always_comb begin
        decide = enable && upd_stb;
        if (up && !dn)      req = MV_INC;
        else if (dn && !up) req = MV_DEC;
        else                req = MV_NONE;
    end
endmodule

// File: rtl/ftc_code_reg.sv
// Saturating fine code register, with a change pulse and a limit flag.
// Assumes one decision per strobe and at most one step per decision.
// The code is held at zero whenever enable is low.
module ftc_code_reg
    import ftc_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              decide,
    input  move_t             req,
    output logic [CODE_W-1:0] code_q,
    output logic              chg_q,
    output logic              sat_q,
    output move_t             mv_act
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    logic blocked;

    // Find whether the requested step is blocked by a limit, and which step applies.
    always_comb begin
        blocked = decide && ((req == MV_INC && code_q == CODE_MAX) ||
                             (req == MV_DEC && code_q == '0));
        if (!decide || blocked) mv_act = MV_NONE;
        else                    mv_act = req;
    end

    // Code register: zero when idle, one step per applied move.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)      code_q <= '0;
        else if (mv_act == MV_INC)  code_q <= code_q + CODE_ONE;
        else if (mv_act == MV_DEC)  code_q <= code_q - CODE_ONE;
    end

    // Change pulse and saturation flag, both refreshed per decision.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            chg_q <= 1'b0;
            sat_q <= 1'b0;
        end else begin
            chg_q <= (mv_act != MV_NONE);
            if (decide) sat_q <= blocked;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (code_q == '0 && !chg_q && !sat_q)); // R2
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !decide) |=> $stable(code_q)); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (code_q == $past(code_q) || code_q == $past(code_q) + CODE_ONE
                    || code_q + CODE_ONE == $past(code_q))); // R4
    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && code_q == CODE_MAX) |=> code_q != '0); // R6
    AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && code_q == '0) |=> code_q != CODE_MAX); // R6
    AST_CHG_MEANS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> code_q != $past(code_q)); // R7
endmodule

// File: rtl/ftc_lock_det.sv
// Lock detector for the fine loop. It counts decisions that hold the code
// or reverse the most recent step, and declares lock at LOCK_K of them.
// Two steps the same way, with any holds between them, clear the count.
// Assumes mv_act is the step actually applied, not the one requested.
module ftc_lock_det
    import ftc_pkg::*;
#(
    parameter int LOCK_K = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  decide,
    input  move_t mv_act,
    output logic  locked_q
);
    localparam int SW = $clog2(LOCK_K + 1);
    localparam logic [SW-1:0] K_V = SW'(LOCK_K);

    move_t          last_q;
    logic [SW-1:0]  streak_q;
    logic [SW-1:0]  streak_nx;
    logic           repeat_step;

    // Classify this decision and compute the next streak count.
    always_comb begin
        repeat_step = decide && mv_act != MV_NONE && mv_act == last_q;
        if (!decide)                streak_nx = streak_q;
        else if (repeat_step)       streak_nx = '0;
        else if (streak_q == K_V)   streak_nx = K_V;
        else                        streak_nx = streak_q + SW'(1);
    end

    // Streak, last applied direction and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            streak_q <= '0;
            last_q   <= MV_NONE;
            locked_q <= 1'b0;
        end else begin
            streak_q <= streak_nx;
            if (decide && mv_act != MV_NONE) last_q <= mv_act;
            locked_q <= (streak_nx == K_V);
        end
    end

    AST_LOCK_NEEDS_STREAK: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |-> streak_q == K_V); // R8
    AST_REPEAT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && repeat_step) |=> !locked_q); // R9
endmodule

// File: rtl/fine_track_ctrl.sv
// Top of the fine delay tracking controller. It holds the fine code at
// zero until the coarse loop is done, then moves it one step per strobe
// toward phase alignment and reports lock, change and saturation.
// Assumes up/dn are synchronous to clk and stable at each strobe.
module fine_track_ctrl
    import ftc_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int LOCK_K = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coarse_done,
    input  logic              up,
    input  logic              dn,
    input  logic              upd_stb,
    output logic [CODE_W-1:0] fine_code,
    output logic              fine_lock,
    output logic              code_chg,
    output logic              fine_sat
);
    logic  decide;
    move_t req;
    move_t mv_act;

    ftc_decide u_decide (
        .enable  (coarse_done),
        .upd_stb (upd_stb),
        .up      (up),
        .dn      (dn),
        .decide  (decide),
        .req     (req)
    );

    ftc_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (coarse_done),
        .decide (decide),
        .req    (req),
        .code_q (fine_code),
        .chg_q  (code_chg),
        .sat_q  (fine_sat),
        .mv_act (mv_act)
    );

    ftc_lock_det #(.LOCK_K(LOCK_K)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (coarse_done),
        .decide   (decide),
        .mv_act   (mv_act),
        .locked_q (fine_lock)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (fine_code == '0 && !fine_lock && !code_chg && !fine_sat)); // R1
    AST_BALANCED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_done && upd_stb && up == dn) |=> $stable(fine_code)); // R5
endmodule

// File: tb/fine_track_ctrl_bench.sv
module fine_track_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coarse_done = 1'b0;
    logic       up = 1'b0;
    logic       dn = 1'b0;
    logic       upd_stb = 1'b0;
    logic [4:0] fine_code;
    logic       fine_lock, code_chg, fine_sat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fine_track_ctrl #(.CODE_W(5), .LOCK_K(3)) u_fine_track_ctrl (
        .clk(clk), .rst_n(rst_n), .coarse_done(coarse_done), .up(up), .dn(dn),
        .upd_stb(upd_stb), .fine_code(fine_code), .fine_lock(fine_lock),
        .code_chg(code_chg), .fine_sat(fine_sat)
    );

    // Vector fields: strobe, up, dn, code[4:0], lock, chg, sat. LOCK_K = 3.
    localparam logic [10:0] VEC [13] = '{
        {3'b110, 5'd1, 3'b010},  // R4 first step up
        {3'b010, 5'd1, 3'b000},  // R3 no strobe, hold
        {3'b110, 5'd2, 3'b010},  // R9 repeat up restarts count
        {3'b101, 5'd1, 3'b010},  // R4 step down, reversal
        {3'b111, 5'd1, 3'b000},  // R5 both high holds
        {3'b100, 5'd1, 3'b100},  // R5 R8 neither holds, lock reached
        {3'b110, 5'd2, 3'b110},  // R8 reversal keeps lock
        {3'b101, 5'd1, 3'b110},  // R8 reversal keeps lock
        {3'b101, 5'd0, 3'b010},  // R9 repeat down clears lock
        {3'b101, 5'd0, 3'b001},  // R6 blocked at floor
        {3'b000, 5'd0, 3'b001},  // R6 flag held between decisions
        {3'b110, 5'd1, 3'b010},  // R6 R7 unblocked decision clears flag
        {3'b110, 5'd2, 3'b010}   // R9 repeat up after reversal
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge and return at the next falling edge.
    task automatic step(input logic s, input logic u, input logic d);
        upd_stb = s; up = u; dn = d;
        @(negedge clk);
    endtask

    task automatic restart_coarse();
        coarse_done = 1'b0;
        step(0, 0, 0);
        coarse_done = 1'b1;
    endtask

    // Closed-loop run: code delay 5 ps per step against a required delay.
    task automatic track(input int req_ps, input int n_dec);
        for (int i = 0; i < n_dec; i++) begin
            for (int c = 0; c < 3; c++) step(0, 0, 0);
            if (int'(fine_code) * 5 < req_ps) step(1, 1, 0);
            else                              step(1, 0, 1);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(0, 0, 0);
        step(0, 0, 0);
        // R1 reset state
        check("R1 code", fine_code, 0);
        check("R1 flags", {fine_lock, code_chg, fine_sat}, 0);
        rst_n = 1'b1;
        // R2: strobed UP ignored while coarse loop is searching
        step(1, 1, 0);
        step(1, 1, 0);
        check("R2 code idle", fine_code, 0);
        check("R2 flags idle", {fine_lock, code_chg, fine_sat}, 0);

        coarse_done = 1'b1;
        for (int i = 0; i < 13; i++) begin
            step(VEC[i][10], VEC[i][9], VEC[i][8]);
            check($sformatf("R4 vec%0d code", i), fine_code, VEC[i][7:3]);
            check($sformatf("R8 vec%0d lock", i), fine_lock, VEC[i][2]);
            check($sformatf("R7 vec%0d chg", i), code_chg, VEC[i][1]);
            check($sformatf("R6 vec%0d sat", i), fine_sat, VEC[i][0]);
        end
        step(0, 0, 0);
        check("R7 pulse one cycle", code_chg, 0);

        // R2: dropping coarse_done returns to zero and clears flags
        coarse_done = 1'b0;
        step(0, 0, 0);
        check("R2 code cleared", fine_code, 0);
        check("R2 flags cleared", {fine_lock, code_chg, fine_sat}, 0);

        // R6: ceiling at 31
        coarse_done = 1'b1;
        for (int i = 0; i < 31; i++) step(1, 1, 0);
        check("R6 top code", fine_code, 31);
        check("R6 top not sat yet", fine_sat, 0);
        step(1, 1, 0);
        check("R6 no wrap", fine_code, 31);
        check("R6 sat at top", fine_sat, 1);
        check("R7 no chg when blocked", code_chg, 0);
        step(1, 1, 0);
        check("R6 still 31", fine_code, 31);

        // R10: frequency drops followed by closed-loop tracking
        restart_coarse();
        track(32, 20);
        check("R10 first match", (fine_code == 6 || fine_code == 7), 1);
        check("R10 first lock", fine_lock, 1);
        track(77, 3);
        check("R9 drop unlocks", fine_lock, 0);
        track(77, 20);
        check("R10 second match", (fine_code == 15 || fine_code == 16), 1);
        check("R10 second lock", fine_lock, 1);

        // R1: reset while running
        rst_n = 1'b0;
        step(0, 0, 0);
        check("R1 reset mid-run", fine_code, 0);
        check("R1 reset lock", fine_lock, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule